// File: doc/BRIEF.md
# Dual External Interrupt Request Channel

This block serves two external interrupt request pins. Each pin has a control register that holds a 3-bit priority, a mask, a choice between rising-edge and active-high level sensing, a cascade enable and a special-nesting flag. Software writes and reads these registers through a small write/read port. Each pin is first synchronized. The block then decides which unmasked channel is asking for service. It presents one pending request, the index of the winning channel and that channel's interrupt type number.

The CPU side answers with a single-cycle acknowledge. That acknowledge always applies to the channel that is winning at that moment. If that channel has cascade mode on, the block drives a one-cycle acknowledge pulse for it. This pulse goes out on a neighbouring pin, which the block switches from input to output while cascade is enabled, so that an external slave controller can place its own vector. In both sensing modes the source must hold its pin high until it is acknowledged. A request whose pin falls early is withdrawn.

Top module: `ext_irq_pair`

## Requirements
- R1: When a request is pending, `irq_type` is 0x0C if channel 0 wins and 0x0D if channel 1 wins. `irq_win` gives the index of the winning channel.
- R2: Each control register resets to 0x000F. The field positions are: priority in bits 2:0, mask in bit 3, level-sense in bit 4, cascade in bit 5 and special-nesting in bit 6. Bits 15:7 always read as zero, and writes to them are dropped.
- R3: While a channel's mask bit (bit 3) is 1, that channel never contributes a request.
- R4: With bit 4 = 0, a low-to-high transition on the pin becomes a pending request at the third rising clock edge after the pin rises. The request stays pending while the pin stays high.
- R5: With bit 4 = 1, the channel requests whenever its synchronized pin is high.
- R6: If the pin falls before an acknowledge, the request is withdrawn once the low level has passed the synchronizer.
- R7: When both channels request, the lower priority value wins. Equal values go to channel 0.
- R8: An acknowledge (`cpu_ack` high for one cycle while `irq_req` is high) clears the pending state of a winning edge-sensed channel. A level-sensed channel keeps requesting while its pin stays high.
- R9: While a channel's cascade bit (bit 5) is 1, its `ack_pin_oe` bit is 1. Acknowledging that channel raises its `ack_pin_o` bit for exactly one cycle, in the cycle after the acknowledge. A channel without cascade produces no pulse.
- R10: The special-nesting bit (bit 6) is stored and reads back as written.
- R11: A register write takes effect at the clock edge that samples `wr_en`. `rd_data` always shows the current value of the register selected by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Channel register chosen for the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Channel register chosen for the read |
| rd_data | output | 16 | Read data, bits 15:7 zero |
| irq_in | input | 2 | External request pins, one per channel |
| cpu_ack | input | 1 | Acknowledge from the CPU for the current winner |
| irq_req | output | 1 | A request is pending |
| irq_win | output | 1 | Index of the winning channel |
| irq_type | output | 8 | Interrupt type number of the winner |
| ack_pin_o | output | 2 | Cascade acknowledge pulse per channel |
| ack_pin_oe | output | 2 | Output enable of the shared pin per channel |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and a type base of 0x0C. Because of that, the sensing latency is an exact number of cycles, so the bench checks the edge-mode and withdrawal timing on a fixed cycle and does not need a window. With the base left at 0x0C, the two type numbers show up directly on the outputs. The three-bit priority width leaves room for the tie case and for both orders of the two priority values.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int CTRL_W    = 16;
  localparam int PRIO_W    = 3;
  localparam int CTRL_BITS = PRIO_W + 4;

  typedef struct packed {
    logic              sfnm;
    logic              casc;
    logic              lvl;
    logic              mask;
    logic [PRIO_W-1:0] prio;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{sfnm: 1'b0, casc: 1'b0, lvl: 1'b0,
                                 mask: 1'b1, prio: '1};
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb sh_n = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin,
  input  logic                 wr_en,
  input  logic [CTRL_BITS-1:0] wr_bits,
  input  logic                 ack_this,
  output ctrl_t                ctrl,
  output logic                 req
);
  logic  pin_s;
  logic  pin_d;
  logic  pend_q, pend_n;
  ctrl_t ctrl_q, ctrl_n;

  eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en) ctrl_n = ctrl_t'(wr_bits);
  end

  always_comb begin
    pend_n = pend_q;
    if (pin_s && !pin_d && !ctrl_q.mask) pend_n = 1'b1;
    if (ack_this || !pin_s || ctrl_q.mask) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      pend_q <= 1'b0;
      pin_d  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      pend_q <= pend_n;
      pin_d  <= pin_s;
    end
  end

  assign ctrl = ctrl_q;
  assign req  = !ctrl_q.mask && (ctrl_q.lvl ? pin_s : pend_q);
endmodule

// File: rtl/eirq_arb.sv
module eirq_arb #(
  parameter int PRIO_W = 3
) (
  input  logic [1:0]        req,
  input  logic [PRIO_W-1:0] prio0,
  input  logic [PRIO_W-1:0] prio1,
  output logic              any,
  output logic              win
);
  always_comb begin
    any = |req;
    win = req[1] && (!req[0] || (prio1 < prio0));
  end
endmodule

// File: rtl/ext_irq_pair.sv
module ext_irq_pair
  import eirq_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] VEC_BASE    = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [CTRL_W-1:0] rd_data,
  input  logic [1:0]        irq_in,
  input  logic              cpu_ack,
  output logic              irq_req,
  output logic              irq_win,
  output logic [7:0]        irq_type,
  output logic [1:0]        ack_pin_o,
  output logic [1:0]        ack_pin_oe
);
  localparam int NCH = 2;

  logic [1:0] rs_q;
  logic       rst_sync_n;
  ctrl_t      ch_ctrl [NCH];
  logic [NCH-1:0] chan_req;
  logic [NCH-1:0] ack_hit;
  logic [NCH-1:0] pulse_q, pulse_n;
  logic       any_req;
  logic       win_idx;
  logic       unused_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n  = rs_q[1];
  assign unused_rsvd = ^wr_data[CTRL_W-1:CTRL_BITS];

  eirq_arb #(.PRIO_W(PRIO_W)) u_arb (
    .req(chan_req), .prio0(ch_ctrl[0].prio), .prio1(ch_ctrl[1].prio),
    .any(any_req), .win(win_idx)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    eirq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pin     (irq_in[i]),
      .wr_en   (wr_en && (wr_sel == 1'(i))),
      .wr_bits (wr_data[CTRL_BITS-1:0]),
      .ack_this(ack_hit[i]),
      .ctrl    (ch_ctrl[i]),
      .req     (chan_req[i])
    );
    assign ack_hit[i]    = cpu_ack && any_req && (win_idx == 1'(i));
    assign pulse_n[i]    = ack_hit[i] && ch_ctrl[i].casc;
    assign ack_pin_oe[i] = ch_ctrl[i].casc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pulse_q <= '0;
    else             pulse_q <= pulse_n;
  end

  assign ack_pin_o = pulse_q;
  assign irq_req   = any_req;
  assign irq_win   = win_idx;
  assign irq_type  = VEC_BASE + {7'd0, win_idx};
  assign rd_data   = {{(CTRL_W-CTRL_BITS){1'b0}}, ch_ctrl[rd_sel]};
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
  import eirq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ack,
  input logic        irq_req,
  input logic        irq_win,
  input logic [7:0]  irq_type,
  input logic [15:0] rd_data,
  input logic [1:0]  chan_req,
  input logic [1:0]  ack_pin_o,
  input ctrl_t       c0,
  input ctrl_t       c1
);
  // R1
  type_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_type == (irq_win ? 8'h0D : 8'h0C));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:7] == 9'd0);
  // R3
  mask0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c0.mask |-> !chan_req[0]);
  // R3
  mask1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c1.mask |-> !chan_req[1]);
  // R7
  prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_win && chan_req[0]) |-> (c1.prio < c0.prio));
  // R7
  prio_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req[0] && (c0.prio <= c1.prio)) |-> !irq_win);
  // R9
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_pin_o) |-> $past(cpu_ack && irq_req));
  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_pin_o));
endmodule

bind ext_irq_pair eirq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_ack(cpu_ack), .irq_req(irq_req),
  .irq_win(irq_win), .irq_type(irq_type), .rd_data(rd_data),
  .chan_req(chan_req), .ack_pin_o(ack_pin_o),
  .c0(ch_ctrl[0]), .c1(ch_ctrl[1])
);

// File: tb/sim_ext_irq_pair.sv
`timescale 1ns/1ps
module sim_ext_irq_pair;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_sel, rd_sel, cpu_ack;
  logic [15:0] wr_data, rd_data;
  logic [1:0]  irq_in, ack_pin_o, ack_pin_oe;
  logic        irq_req, irq_win;
  logic [7:0]  irq_type;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  ext_irq_pair u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_in(irq_in), .cpu_ack(cpu_ack), .irq_req(irq_req),
    .irq_win(irq_win), .irq_type(irq_type), .ack_pin_o(ack_pin_o),
    .ack_pin_oe(ack_pin_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, input string req, input logic [15:0] exp);
    rd_sel = sel;
    #1;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic wait_n(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // driver: acknowledge, pushing the channel whose pulse is expected
  task automatic do_ack(input int exp_ch);
    if (exp_ch >= 0) exp_q.push_back(exp_ch);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  // monitor: every cascade pulse must match the scoreboard head (R9)
  always @(negedge clk) begin
    if (rst_n && ack_pin_o != 2'b00) begin
      if (exp_q.size() == 0) chk("R9 unexpected pulse", 32'(ack_pin_o), 32'd0);
      else begin
        int ch;
        ch = exp_q.pop_front();
        chk("R9 pulse channel", 32'(ack_pin_o), 32'(1 << ch));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rd_sel = 1'b0; cpu_ack = 1'b0; irq_in = 2'b00;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);

    // reset state
    rd(1'b0, "R2 reset ch0", 16'h000F);
    rd(1'b1, "R2 reset ch1", 16'h000F);
    chk("R3 no req after reset", 32'(irq_req), 0);

    // reserved bits dropped
    wr(1'b0, 16'hFFFF);
    rd(1'b0, "R2 reserved zero", 16'h007F);
    wr(1'b0, 16'h0002);

    // masked channel 1
    irq_in[1] = 1'b1; wait_n(5);
    chk("R3 masked ch1 silent", 32'(irq_req), 0);
    irq_in[1] = 1'b0; wait_n(4);

    // edge mode latency on channel 0
    irq_in[0] = 1'b1;
    wait_n(2);
    chk("R4 not yet pending", 32'(irq_req), 0);
    wait_n(1);
    chk("R4 pending at third edge", 32'(irq_req), 1);
    chk("R1 type ch0", 32'(irq_type), 32'h0C);
    wait_n(3);
    chk("R4 held while high", 32'(irq_req), 1);

    // withdraw
    irq_in[0] = 1'b0; wait_n(3);
    chk("R6 withdrawn", 32'(irq_req), 0);

    // ack clears edge channel while pin stays high
    irq_in[0] = 1'b1; wait_n(4);
    do_ack(-1);
    chk("R8 edge cleared by ack", 32'(irq_req), 0);
    irq_in[0] = 1'b0; wait_n(4);

    // level mode channel 1
    wr(1'b1, 16'h0011);
    irq_in[1] = 1'b1; wait_n(3);
    chk("R5 level request", 32'(irq_req), 1);
    chk("R1 type ch1", 32'(irq_type), 32'h0D);
    do_ack(-1);
    wait_n(1);
    chk("R8 level persists", 32'(irq_req), 1);

    // priority: ch0 prio2 edge, ch1 prio1 level
    irq_in[0] = 1'b1; wait_n(4);
    chk("R7 lower value wins", 32'(irq_win), 1);
    wr(1'b1, 16'h0012);
    chk("R7 tie to ch0", 32'(irq_win), 0);
    chk("R1 type on tie", 32'(irq_type), 32'h0C);
    wr(1'b0, 16'h0005);
    chk("R7 ch1 wins again", 32'(irq_win), 1);
    irq_in = 2'b00; wait_n(4);
    chk("R6 both withdrawn", 32'(irq_req), 0);

    // cascade on channel 0, write timing
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0020;
    #1 chk("R11 before edge", 32'(ack_pin_oe), 0);
    @(negedge clk); wr_en = 1'b0;
    chk("R9 oe after write", 32'(ack_pin_oe), 1);
    rd(1'b0, "R11 read current", 16'h0020);
    irq_in[0] = 1'b1; wait_n(4);
    chk("R1 winner ch0", 32'(irq_win), 0);
    do_ack(0);
    @(negedge clk);
    chk("R9 pulse single", 32'(ack_pin_o), 0);
    chk("R8 cleared after cascade ack", 32'(irq_req), 0);
    irq_in[0] = 1'b0; wait_n(4);

    // special nesting bit storage
    wr(1'b1, 16'h0047);
    rd(1'b1, "R10 nesting bit", 16'h0047);

    wait_n(2);
    chk("R9 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule